// File: doc/BRIEF.md
# Octet-Escaped Link Frame Encoder

This block turns a packet into a byte-oriented link frame. Upstream presents the packet one byte at a time with start and end markers under a valid/ready handshake. Downstream receives one frame byte per accepted cycle.

Each frame is built in this order:

- an opening flag (0x7E);
- a header of address, control and a two-byte protocol identifier, all taken from configuration inputs;
- the payload;
- an optional 32-bit check sequence;
- a closing flag.

After the closing flag, a programmed number of fill flags follows. Inside the frame body, any flag or escape octet is replaced by a two-byte escape sequence.

The encoder holds the header itself and emits it before it accepts the first payload byte. Upstream ready is the only flow-control path. It drops whenever the encoder cannot take a byte in the current cycle: while the header goes out, while an escape prefix goes out, and while the check sequence and flags go out.

Top module: `laps_tx_encoder`

## Requirements
- R1: After reset, `out_valid` is low and stays low until a byte marked with `in_sop` is offered.
- R2: A frame is sent in this order: 0x7E, `cfg_addr`, `cfg_ctrl`, `cfg_proto[15:8]`, `cfg_proto[7:0]`, the payload bytes in arrival order, the check sequence (when enabled), 0x7E. The value 0x7E appears on `out_data` only as an opening, closing or fill flag.
- R3: A body byte equal to 0x7E is sent as 0x7D followed by 0x5E.
- R4: A body byte equal to 0x7D is sent as 0x7D followed by 0x5D.
- R5: The check sequence is a CRC-32 over the header and payload bytes before escaping. It uses the reflected polynomial 0xEDB88320 with an all-ones start value, is complemented when sent, and goes out least significant byte first. Each of its bytes is escaped as in R3/R4.
- R6: When `cfg_fcs_en` is low at the opening flag's transfer, the frame carries no check sequence, and the closing flag follows the last payload byte.
- R7: When `cfg_fcs_corrupt` is high at the opening flag's transfer, that frame's check sequence is sent uncomplemented.
- R8: After the closing flag, exactly `cfg_fill_cnt` fill flags (0x7E) are sent, with zero meaning none. `out_valid` then stays low until the next start byte is offered.
- R9: While an escape prefix is being sent, `in_ready` is low, so no payload byte is lost. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.
- R10: Bytes offered without `in_sop` while no frame is in progress are accepted and discarded, and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Address byte of the header |
| cfg_ctrl | input | 8 | Control byte of the header |
| cfg_proto | input | 16 | Protocol identifier, high byte sent first |
| cfg_fcs_en | input | 1 | Append the check sequence |
| cfg_fcs_corrupt | input | 1 | Send the check sequence uncomplemented (test aid) |
| cfg_fill_cnt | input | FILL_W | Fill flags sent after each frame |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input payload byte |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_eop | input | 1 | Input byte is the last of a packet |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output frame byte |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
The hold and escape-pair assertions assume that upstream keeps `in_valid`, `in_data` and the markers steady until `in_ready` takes the byte. They also assume that the configuration inputs do not change while a frame is in flight. The stimulus meets both assumptions. Its driver changes an input byte only after the edge at which it was accepted. It also waits until every expected byte of a frame, including the fill flags, has left the encoder before it reprograms the header, check-sequence or fill settings. Downstream ready toggles pseudo-randomly in most frames, so that escape prefixes, header bytes and check-sequence bytes all meet back-pressure.

// File: rtl/laps_tx_encoder.sv
module laps_tx_encoder #(
  parameter int          FILL_W    = 8,
  parameter logic [31:0] POLY_REFL = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_ctrl,
  input  logic [15:0]       cfg_proto,
  input  logic              cfg_fcs_en,
  input  logic              cfg_fcs_corrupt,
  input  logic [FILL_W-1:0] cfg_fill_cnt,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready
);
  localparam logic [7:0] FLAG  = 8'h7E;
  localparam logic [7:0] ESC   = 8'h7D;
  localparam logic [7:0] XMASK = 8'h20;

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN, S_ADDR, S_CTRL, S_PHI, S_PLO, S_DATA, S_FCS, S_CLOSE, S_FILL
  } st_t;

  st_t               st;
  logic              esc_pend, fcs_on, fcs_raw;
  logic [31:0]       crc;
  logic [1:0]        fidx;
  logic [FILL_W-1:0] fill_left;
  logic              body, special, hs, adv, crc_state;
  logic [7:0]        cur;
  logic [31:0]       fcs_word;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
    return r;
  endfunction

  assign body      = st inside {S_ADDR, S_CTRL, S_PHI, S_PLO, S_DATA, S_FCS};
  assign crc_state = st inside {S_ADDR, S_CTRL, S_PHI, S_PLO, S_DATA};
  assign fcs_word  = fcs_raw ? crc : ~crc;

  always_comb begin
    case (st)
      S_ADDR:  cur = cfg_addr;
      S_CTRL:  cur = cfg_ctrl;
      S_PHI:   cur = cfg_proto[15:8];
      S_PLO:   cur = cfg_proto[7:0];
      S_DATA:  cur = in_data;
      S_FCS:   cur = fcs_word[8*fidx +: 8];
      default: cur = FLAG;
    endcase
  end

  assign special   = (cur == FLAG) || (cur == ESC);
  assign out_valid = (st == S_DATA) ? in_valid : (st != S_IDLE);
  assign out_data  = !body ? FLAG : esc_pend ? (cur ^ XMASK) : special ? ESC : cur;
  assign hs        = out_valid && out_ready;
  assign adv       = hs && (!body || esc_pend || !special);
  assign in_ready  = (st == S_IDLE && !in_sop) ||
                     (st == S_DATA && out_ready && (esc_pend || !special));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      esc_pend  <= 1'b0;
      fcs_on    <= 1'b1;
      fcs_raw   <= 1'b0;
      crc       <= '1;
      fidx      <= '0;
      fill_left <= '0;
    end else begin
      if (hs && body && !esc_pend && special) esc_pend <= 1'b1;
      else if (adv)                           esc_pend <= 1'b0;

      if (adv && crc_state) crc <= crc_step(crc, cur);

      case (st)
        S_IDLE: if (in_valid && in_sop) st <= S_OPEN;
        S_OPEN: if (adv) begin
          crc     <= '1;
          fcs_on  <= cfg_fcs_en;
          fcs_raw <= cfg_fcs_corrupt;
          st      <= S_ADDR;
        end
        S_ADDR: if (adv) st <= S_CTRL;
        S_CTRL: if (adv) st <= S_PHI;
        S_PHI:  if (adv) st <= S_PLO;
        S_PLO:  if (adv) st <= S_DATA;
        S_DATA: if (adv && in_eop) begin
          st   <= fcs_on ? S_FCS : S_CLOSE;
          fidx <= '0;
        end
        S_FCS: if (adv) begin
          fidx <= fidx + 2'd1;
          if (fidx == 2'd3) st <= S_CLOSE;
        end
        S_CLOSE: if (adv) begin
          fill_left <= cfg_fill_cnt;
          st        <= (cfg_fill_cnt == '0) ? S_IDLE : S_FILL;
        end
        S_FILL: if (adv) begin
          fill_left <= fill_left - 1'b1;
          if (fill_left == FILL_W'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r3_escape_second: assert property (@(posedge clk) disable iff (!rst_n)
    hs && body && !esc_pend && special |=> out_valid && (out_data == 8'h5E || out_data == 8'h5D));

  a_r9_no_take_on_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && st == S_DATA |-> hs && out_data != ESC);

  a_r2_flag_outside_body: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data == FLAG |-> !body);

  a_r8_fill_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FILL |-> fill_left != '0);

  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st) == S_IDLE && st == S_IDLE |-> !out_valid);
endmodule

// File: tb/laps_tx_encoder_tb.sv
module laps_tx_encoder_tb;
  localparam int FILL_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_addr = 8'h03, cfg_ctrl = 8'h13;
  logic [15:0] cfg_proto = 16'hFE01;
  logic cfg_fcs_en = 1'b1, cfg_fcs_corrupt = 1'b0;
  logic [FILL_W-1:0] cfg_fill_cnt = '0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_ready;
  logic [7:0] out_data;

  laps_tx_encoder #(.FILL_W(FILL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_ctrl(cfg_ctrl),
    .cfg_proto(cfg_proto), .cfg_fcs_en(cfg_fcs_en), .cfg_fcs_corrupt(cfg_fcs_corrupt),
    .cfg_fill_cnt(cfg_fill_cnt), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready));

  always #5 clk = ~clk;

  typedef struct { logic [7:0] d; string tag; } item_t;
  item_t exp_q[$];
  logic [7:0] pl[$];
  int nchk = 0, nfail = 0, cycles = 0;
  bit rmode = 1'b0;
  logic [15:0] lf = 16'hACE1;
  logic held_v = 1'b0;
  logic [7:0] held_d = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    out_ready = rmode ? lf[0] : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (held_v) check(out_valid && out_data == held_d, "R9 hold", {24'd0, out_data}, {24'd0, held_d});
    held_v = out_valid && !out_ready;
    held_d = out_data;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R2 extra byte", {24'd0, out_data}, 32'd0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        check(out_data == it.d, it.tag, {24'd0, out_data}, {24'd0, it.d});
      end
    end
  end

  function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] d);
    c ^= {24'd0, d};
    for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  task automatic push_b(input logic [7:0] d, input string tag);
    item_t it;
    it.d = d; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic push_body(input logic [7:0] d, input string tag);
    if (d == 8'h7E) begin push_b(8'h7D, "R3"); push_b(8'h5E, "R3"); end
    else if (d == 8'h7D) begin push_b(8'h7D, "R4"); push_b(8'h5D, "R4"); end
    else push_b(d, tag);
  endtask

  task automatic drive_byte(input logic [7:0] d, input logic s, input logic e);
    bit got = 1'b0;
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    while (!got) begin @(negedge clk); got = in_ready; end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid, "R8 quiet after fill", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic run_frame();
    logic [31:0] crc = '1;
    logic [31:0] f;
    logic [7:0] hdr[4];
    hdr = '{cfg_addr, cfg_ctrl, cfg_proto[15:8], cfg_proto[7:0]};
    push_b(8'h7E, "R2 open");
    foreach (hdr[i]) begin crc = crc_b(crc, hdr[i]); push_body(hdr[i], "R2 header"); end
    foreach (pl[i]) begin crc = crc_b(crc, pl[i]); push_body(pl[i], "R2 payload"); end
    if (cfg_fcs_en) begin
      f = cfg_fcs_corrupt ? crc : ~crc;
      for (int k = 0; k < 4; k++) push_body(f[8*k +: 8], cfg_fcs_corrupt ? "R7" : "R5");
    end
    push_b(8'h7E, cfg_fcs_en ? "R2 close" : "R6 close");
    for (int k = 0; k < int'(cfg_fill_cnt); k++) push_b(8'h7E, "R8");
    foreach (pl[i]) drive_byte(pl[i], i == 0, i == pl.size() - 1);
    wait_drain();
  endtask

  initial begin
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid, "R1 reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(!out_valid, "R1 idle", {31'd0, out_valid}, 32'd0);

    cfg_fill_cnt = 8'd2;
    pl = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h55};
    run_frame();

    rmode = 1'b1;
    cfg_fill_cnt = 8'd0;
    pl = '{8'h7E, 8'h10, 8'h7D, 8'h7E, 8'h7D, 8'h22, 8'h7E};
    run_frame();

    cfg_addr = 8'h7E; cfg_ctrl = 8'h7D; cfg_proto = 16'h7E7D; cfg_fill_cnt = 8'd3;
    pl = '{8'hA5, 8'h7D};
    run_frame();

    cfg_addr = 8'h03; cfg_ctrl = 8'h13; cfg_proto = 16'hFE01;
    cfg_fcs_en = 1'b0; cfg_fill_cnt = 8'd1;
    pl = '{8'h11, 8'h7E, 8'h33};
    run_frame();

    cfg_fcs_en = 1'b1; cfg_fcs_corrupt = 1'b1;
    pl = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
    run_frame();

    cfg_fcs_corrupt = 1'b0; cfg_fill_cnt = 8'd5;
    pl = '{8'h7D};
    run_frame();

    rmode = 1'b0;
    for (int j = 0; j < 3; j++) begin
      in_valid = 1'b1; in_data = 8'h7E; in_sop = 1'b0; in_eop = 1'b0;
      @(negedge clk);
      check(in_ready == 1'b1, "R10 accept", {31'd0, in_ready}, 32'd1);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(!out_valid && exp_q.size() == 0, "R10 no output", {31'd0, out_valid}, 32'd0);

    rmode = 1'b1; cfg_fill_cnt = 8'd0;
    pl = '{};
    for (int j = 0; j < 20; j++) pl.push_back(8'(j * 13 + 8'h70));
    run_frame();

    finish_run();
  end
endmodule